// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a CPU register bus and a one-time-programmable fuse array. Software enables CPU access and selects an operation in the command register. It loads a row address and write data, then launches the operation by setting the start bit. It polls the status register for completion. Reads fetch one row from the array into read-data registers. Programs push write data to the array, where fuses can only move from 0 to 1.

Programming is locked at reset. To unlock it, software issues the program-enable command four times in a row, with the write-data register holding a fixed key at each step. Each step reports completion. After the fourth correct step, the programming-allowed status bit rises. A program-disable command locks the array again. The parameter `ROW_WORDS` selects rows of one or two 32-bit words. The array sits behind a request/acknowledge port, so its latency, which grows with the number of set bits, is the array's own affair.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset every register reads as 0, including status (offset 0x0C), mode (0x00) and read-data word 0 (0x10).
- R2: While bit 0 of the mode register (0x00) is clear, a write of 1 to the start register (0x08) launches nothing: the status done bit stays 0 and no array request is made.
- R3: The address register (0x28) keeps only its low 16 bits. A read-back returns the written value masked to 16 bits, and that value is the row sent to the array.
- R4: Command code 0x0 (the command register at 0x04 is 6 bits wide) reads the addressed row. Word 0 appears at 0x10, word 1 at 0x5C in two-word rows, and status bit 1 (done) is set.
- R5: The array unlocks after four program-enable commands (code 0x2) whose write-data word 0 (0x2C) holds 0xF, 0x4, 0x8 and 0xD in that order. Each step sets done, and status bit 2 (programming allowed) rises after the fourth.
- R6: A program-enable step with a wrong key returns the key tracker to its first step, so a sequence with any wrong step leaves status bit 2 clear.
- R7: A program command (code 0x8) issued while locked sets done and leaves the array contents unchanged.
- R8: A program command issued while unlocked sends word 0 (0x2C) and, in two-word rows, word 1 (0x64) to the addressed row. Because the array only sets bits, a read-back shows the OR of the old contents and every word programmed.
- R9: Program-disable (code 0x3) clears status bit 2 and sets done.
- R10: Writing 0 to the start register clears done. A start write while an array operation is in flight is ignored.
- R11: An array request stays asserted, with a constant row and direction, until the array acknowledges it. A write request is never issued while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| fuse_req | output | 1 | Array operation request |
| fuse_we | output | 1 | 1 = program, 0 = read |
| fuse_row | output | 16 | Row address |
| fuse_wdata | output | 32*ROW_WORDS | Data to program |
| fuse_rdata | input | 32*ROW_WORDS | Row read from the array, valid with fuse_ack |
| fuse_ack | input | 1 | One-cycle completion from the array |

## Verification
A register write is visible on read-back the cycle after the clock edge that takes it. Commands that touch no fuse set done on the edge that takes the start write. Read and program set done, and fill the read-data registers, on the edge after the array raises its acknowledge. The array model's latency depends on the operation and the number of set bits, so the bench never counts cycles for array commands. It polls the done bit and samples every register two nanoseconds after a rising edge, once that edge's updates are settled. The in-flight start test uses a program of all ones, which keeps the array busy for more than sixty cycles. Its ignored start writes therefore fall inside that window.

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
  parameter int ROW_WORDS = 1,
  parameter int ADDR_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [7:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    fuse_req,
  output logic                    fuse_we,
  output logic [ADDR_W-1:0]       fuse_row,
  output logic [32*ROW_WORDS-1:0] fuse_wdata,
  input  logic [32*ROW_WORDS-1:0] fuse_rdata,
  input  logic                    fuse_ack
);
  localparam int  RW   = 32 * ROW_WORDS;
  localparam bit  WIDE = (ROW_WORDS == 2);

  localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_START = 8'h08,
                         A_STAT = 8'h0C, A_RD0 = 8'h10, A_ADDR  = 8'h28,
                         A_WR0  = 8'h2C, A_RD1 = 8'h5C, A_WR1   = 8'h64;
  localparam logic [5:0] C_READ = 6'h00, C_EN = 6'h02, C_DIS = 6'h03, C_PROG = 6'h08;

  typedef enum logic {IDLE, WAIT} state_t;
  state_t state;

  logic              mode_q, start_q, done, prog_ok, op_we;
  logic [5:0]        cmd_q;
  logic [1:0]        step_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wr0, wr1, rd0, rd1, rd1_in, key;

  generate
    if (WIDE) begin : g_two
      assign fuse_wdata = {wr1, wr0};
      assign rd1_in     = fuse_rdata[RW-1 -: 32];
    end else begin : g_one
      assign fuse_wdata = wr0;
      assign rd1_in     = 32'h0;
    end
  endgenerate

  assign fuse_req = (state == WAIT);
  assign fuse_we  = op_we;
  assign fuse_row = addr_q;

  always_comb begin
    case (step_q)
      2'd0: key = 32'hF;
      2'd1: key = 32'h4;
      2'd2: key = 32'h8;
      default: key = 32'hD;
    endcase
  end

  wire wr_hit = bus_we && (state == IDLE || bus_addr != A_START);
  wire launch = bus_we && bus_addr == A_START && bus_wdata[0] && mode_q && state == IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE; mode_q <= 1'b0; start_q <= 1'b0; done <= 1'b0;
      prog_ok <= 1'b0; op_we <= 1'b0; cmd_q <= '0; step_q <= '0;
      addr_q <= '0; wr0 <= '0; wr1 <= '0; rd0 <= '0; rd1 <= '0;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          A_MODE:  mode_q  <= bus_wdata[0];
          A_CMD:   cmd_q   <= bus_wdata[5:0];
          A_START: start_q <= bus_wdata[0];
          A_ADDR:  addr_q  <= bus_wdata[ADDR_W-1:0];
          A_WR0:   wr0     <= bus_wdata;
          A_WR1:   if (WIDE) wr1 <= bus_wdata;
          default: ;
        endcase
      end
      if (wr_hit && bus_addr == A_START && !bus_wdata[0]) done <= 1'b0;
      if (launch) begin
        done <= 1'b1;
        case (cmd_q)
          C_READ: begin done <= 1'b0; op_we <= 1'b0; state <= WAIT; end
          C_PROG: if (prog_ok) begin done <= 1'b0; op_we <= 1'b1; state <= WAIT; end
          C_DIS:  begin prog_ok <= 1'b0; step_q <= '0; end
          C_EN:   begin
            if (wr0 != key)        step_q <= '0;
            else if (step_q == 2'd3) begin step_q <= '0; prog_ok <= 1'b1; end
            else                   step_q <= step_q + 2'd1;
          end
          default: ;
        endcase
      end
      if (state == WAIT && fuse_ack) begin
        state <= IDLE;
        done  <= 1'b1;
        if (!op_we) begin
          rd0 <= fuse_rdata[31:0];
          rd1 <= rd1_in;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {31'h0, mode_q};
      A_CMD:   bus_rdata = {26'h0, cmd_q};
      A_START: bus_rdata = {31'h0, start_q};
      A_STAT:  bus_rdata = {29'h0, prog_ok, done, 1'b0};
      A_RD0:   bus_rdata = rd0;
      A_RD1:   bus_rdata = rd1;
      A_ADDR:  bus_rdata = {{(32-ADDR_W){1'b0}}, addr_q};
      A_WR0:   bus_rdata = wr0;
      A_WR1:   bus_rdata = wr1;
      default: bus_rdata = 32'h0;
    endcase
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_req && !fuse_ack |=> fuse_req && $stable(fuse_row) && $stable(fuse_we));
  assert_prog_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_req && fuse_we |-> prog_ok);
  assert_unlock_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_ok) |-> $past(step_q == 2'd3 && cmd_q == C_EN));
  assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == IDLE && !mode_q |=> state == IDLE);
  assert_done_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == A_START && !bus_wdata[0] && state == IDLE |=> !done);
endmodule

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
  localparam int RW = 64;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic fuse_req, fuse_we, fuse_ack = 1'b0;
  logic [15:0] fuse_row;
  logic [RW-1:0] fuse_wdata, fuse_rdata = '0;

  otp_fuse_ctrl #(.ROW_WORDS(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_req(fuse_req),
    .fuse_we(fuse_we), .fuse_row(fuse_row), .fuse_wdata(fuse_wdata),
    .fuse_rdata(fuse_rdata), .fuse_ack(fuse_ack));

  always #5 clk = ~clk;

  function automatic logic [RW-1:0] init_row(int r);
    return {32'hA500_0000 | 32'(r), 32'h00C3_0000 | 32'(r)};
  endfunction

  logic [RW-1:0] mem [64];
  logic mbusy = 1'b0;
  int mcnt = 0;
  always @(posedge clk) begin
    fuse_ack <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_row(i);
      mbusy <= 1'b0;
    end else if (fuse_req && !fuse_ack) begin
      if (!mbusy) begin
        mbusy <= 1'b1;
        mcnt  <= fuse_we ? 2 + $countones(fuse_wdata) : 3;
      end else if (mcnt == 0) begin
        fuse_ack <= 1'b1;
        mbusy    <= 1'b0;
        if (fuse_we) mem[fuse_row[5:0]] <= mem[fuse_row[5:0]] | fuse_wdata;
        else         fuse_rdata <= mem[fuse_row[5:0]];
      end else mcnt <= mcnt - 1;
    end
  end

  typedef struct { logic [7:0] a; logic [31:0] e; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    #2;
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (bus_rdata !== it.e) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, bus_rdata, it.e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); bus_addr = a;
    it.a = a; it.e = e; it.tag = tag;
    q.push_back(it);
    while (q.size() != 0) @(posedge clk);
    #3;
  endtask

  task automatic poll_done(input string tag);
    for (int n = 0; n < 500; n++) begin
      @(negedge clk); bus_addr = 8'h0C;
      @(posedge clk); #2;
      if (bus_rdata[1]) return;
    end
    checks++; errors++;
    $display("FAIL %s done timeout actual=0 expected=1", tag);
  endtask

  task automatic go(input logic [5:0] c, input string tag);
    wr(8'h04, {26'h0, c});
    wr(8'h08, 32'h1);
    poll_done(tag);
  endtask

  task automatic clr();
    wr(8'h08, 32'h0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] keys [5];
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk(8'h0C, 32'h0, "R1 status");
    chk(8'h00, 32'h0, "R1 mode");
    chk(8'h10, 32'h0, "R1 rdata0");

    wr(8'h04, 32'h0); wr(8'h08, 32'h1);
    repeat (6) @(posedge clk);
    chk(8'h0C, 32'h0, "R2 start ignored when mode clear");
    checks++;
    if (fuse_req !== 1'b0) begin errors++; $display("FAIL R2 fuse_req actual=%b expected=0", fuse_req); end
    clr();

    wr(8'h00, 32'h1);
    wr(8'h28, 32'hABCD_1234);
    chk(8'h28, 32'h0000_1234, "R3 address mask");

    go(6'h00, "R4 read");
    chk(8'h0C, 32'h2, "R4 done");
    chk(8'h10, 32'h00C3_0034, "R4 word0");
    chk(8'h5C, 32'hA500_0034, "R4 word1");
    clr();

    wr(8'h2C, 32'hFFFF_FFFF); wr(8'h64, 32'hFFFF_FFFF);
    go(6'h08, "R7 locked program");
    chk(8'h0C, 32'h2, "R7 done, still locked");
    clr();
    go(6'h00, "R7 readback");
    chk(8'h10, 32'h00C3_0034, "R7 row0 unchanged");
    chk(8'h5C, 32'hA500_0034, "R7 row1 unchanged");
    clr();

    keys[0] = 32'hF; keys[1] = 32'h4; keys[2] = 32'h7; keys[3] = 32'h8; keys[4] = 32'hD;
    for (int i = 0; i < 5; i++) begin
      wr(8'h2C, keys[i]);
      go(6'h02, "R6 bad sequence step");
      clr();
    end
    chk(8'h0C, 32'h0, "R6 wrong key keeps lock");

    keys[2] = 32'h8; keys[3] = 32'hD;
    for (int i = 0; i < 4; i++) begin
      wr(8'h2C, keys[i]);
      go(6'h02, "R5 unlock step");
      chk(8'h0C, (i == 3) ? 32'h6 : 32'h2, "R5 unlock step status");
      clr();
    end

    wr(8'h28, 32'h3);
    wr(8'h2C, 32'h0000_F000); wr(8'h64, 32'h0F00_0000);
    go(6'h08, "R8 program a"); clr();
    wr(8'h2C, 32'h1000_0000); wr(8'h64, 32'h0);
    go(6'h08, "R8 program b"); clr();
    go(6'h00, "R8 readback");
    chk(8'h10, 32'h10C3_F003, "R8 word0 OR");
    chk(8'h5C, 32'hAF00_0003, "R8 word1 OR");
    clr();

    wr(8'h28, 32'h7);
    wr(8'h2C, 32'hFFFF_FFFF); wr(8'h64, 32'hFFFF_FFFF);
    wr(8'h04, 32'h8); wr(8'h08, 32'h1);
    wr(8'h08, 32'h0); wr(8'h04, 32'h3); wr(8'h08, 32'h1);
    poll_done("R10 busy program");
    chk(8'h0C, 32'h6, "R10 start during busy ignored");
    clr();
    chk(8'h0C, 32'h4, "R10 start clear drops done");
    checks++;
    if (fuse_req !== 1'b0) begin errors++; $display("FAIL R11 fuse_req idle actual=%b expected=0", fuse_req); end
    go(6'h00, "R8 all ones");
    chk(8'h10, 32'hFFFF_FFFF, "R8 all ones word0");
    clr();

    go(6'h03, "R9 disable");
    chk(8'h0C, 32'h2, "R9 locked again");
    clr();
    wr(8'h28, 32'h3); wr(8'h2C, 32'h1);
    go(6'h08, "R7 program after disable"); clr();
    go(6'h00, "R7 readback after disable");
    chk(8'h10, 32'h10C3_F003, "R7 unchanged after disable");
    clr();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule